// File: doc/BRIEF.md
# Two-Channel Ring Network Interface

This block connects one node to a unidirectional ring. It has exactly one ring input and one ring output. A local unit hands it outgoing messages on a single flit port. A queuing half sorts each message into a high-priority or a low-priority transmit FIFO, using the priority bit in the message header. The same half keeps a receive FIFO for each priority, and the local unit drains extracted messages from those.

A separate transport half looks at every message that arrives on the ring input. A message addressed to this node is extracted and handed to the queuing half. A message that this node sent, and that came all the way round without being taken, is dropped and flagged. Every other message is passed downstream unchanged. The transport half inserts local messages only between whole passing messages. The two halves meet at a plain flit handshake, so the transport half can be swapped for a different network.

A message is one header flit followed by `len` payload flits. All ports use valid/ready handshakes. While valid is high and ready is low, an offered flit stays unchanged.

Top module: `niu_ring_node`

## Requirements
- R1: After reset, `ring_out_valid_o`, `hi_rx_valid_o`, `lo_rx_valid_o` and `loop_err_o` are all low.
- R2: A header flit is 32 bits wide and laid out as follows: bit 31 is priority (1 = high), bits 30:27 are the destination node, bits 26:23 are the source node, bits 22:19 are `len` (the number of payload flits that follow), bits 18:11 are the tag, bits 10:3 are the command, and bits 2:0 are reserved.
- R3: A locally sent message leaves on `ring_out` unchanged, as its header followed by its `len` payload flits. No flit of another message is placed between them.
- R4: When a message boundary is reached and messages are waiting in both transmit queues, the high-priority message is sent first.
- R5: An arriving message whose destination equals `node_id_i` is not forwarded. It is delivered whole on the receive port that matches its priority bit: `hi_rx` for 1, `lo_rx` for 0.
- R6: An arriving message whose destination and source both differ from `node_id_i` is forwarded unchanged on `ring_out`.
- R7: When a message boundary is reached and both a passing message and a local message are waiting, the passing message goes out first. The local message starts only after the last flit of the passing message.
- R8: An arriving message with source equal to `node_id_i` and destination not equal to `node_id_i` is consumed and appears on no output. `loop_err_o` is high for one cycle, on the cycle after its header is accepted.
- R9: While `ring_out_valid_o` is high and `ring_out_ready_i` is low, the offered flit stays the same, and no flit is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| node_id_i | input | 4 | This node's ring address |
| loc_tx_valid_i | input | 1 | Local outgoing flit is valid |
| loc_tx_ready_o | output | 1 | Local outgoing flit is accepted |
| loc_tx_data_i | input | 32 | Local outgoing flit |
| hi_rx_valid_o | output | 1 | High-priority extracted flit is valid |
| hi_rx_ready_i | input | 1 | Local side accepts the high-priority flit |
| hi_rx_data_o | output | 32 | High-priority extracted flit |
| lo_rx_valid_o | output | 1 | Low-priority extracted flit is valid |
| lo_rx_ready_i | input | 1 | Local side accepts the low-priority flit |
| lo_rx_data_o | output | 32 | Low-priority extracted flit |
| ring_in_valid_i | input | 1 | Upstream ring flit is valid |
| ring_in_ready_o | output | 1 | Upstream ring flit is accepted |
| ring_in_data_i | input | 32 | Upstream ring flit |
| ring_out_valid_o | output | 1 | Downstream ring flit is valid |
| ring_out_ready_i | input | 1 | Downstream stage accepts the flit |
| ring_out_data_o | output | 32 | Downstream ring flit |
| loop_err_o | output | 1 | Pulse when a returning own message is dropped |

## Verification
Some properties are checked on every cycle:
- An offered flit holds steady under backpressure, both at the ring output and at every FIFO output.
- Neither the channel selector nor the ring output owner changes in the middle of a message.
- At an idle boundary, a waiting high-priority queue head or a passing header wins.
- Every error pulse follows an accepted ring flit.

Other behaviour can only be shown by the bench scenarios. These cover the complete flit order when a stalled output is released, how each destination/source combination is sorted onto the forward, receive or drop path, and that a dropped message leaves no trace on any output.

// File: rtl/niu_pkg.sv
package niu_pkg;
  localparam int FLIT_W = 32;
  localparam int NODE_W = 4;
  localparam int LEN_W  = 4;
  localparam int TAG_W  = 8;
  localparam int CMD_W  = 8;
  localparam int RSVD_W = FLIT_W - 1 - 2*NODE_W - LEN_W - TAG_W - CMD_W;

  typedef struct packed {
    logic              prio;
    logic [NODE_W-1:0] dest;
    logic [NODE_W-1:0] src;
    logic [LEN_W-1:0]  len;
    logic [TAG_W-1:0]  tag;
    logic [CMD_W-1:0]  cmd;
    logic [RSVD_W-1:0] rsvd;
  } hdr_t;

  typedef enum logic [1:0] {OWN_NONE, OWN_FWD, OWN_INS} out_own_e;
  typedef enum logic [1:0] {IN_FWD, IN_EXT, IN_DROP} in_mode_e;
endpackage

// File: rtl/niu_fifo.sv
module niu_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push, pop;

  assign in_ready_o  = (cnt_q != CW'(DEPTH));
  assign out_valid_o = (cnt_q != '0);
  assign out_data_o  = mem_q[rd_q];
  assign push        = in_valid_i && in_ready_o;
  assign pop         = out_valid_o && out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem_q[wr_q] <= in_data_i;
  end

  assert_fifo_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));
  assert_fifo_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/niu_msg_queue.sv
module niu_msg_queue
  import niu_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              loc_tx_valid_i,
  output logic              loc_tx_ready_o,
  input  logic [FLIT_W-1:0] loc_tx_data_i,
  output logic              net_tx_valid_o,
  input  logic              net_tx_ready_i,
  output logic [FLIT_W-1:0] net_tx_data_o,
  input  logic              net_rx_valid_i,
  output logic              net_rx_ready_o,
  input  logic [FLIT_W-1:0] net_rx_data_i,
  input  logic              net_rx_prio_i,
  output logic              hi_rx_valid_o,
  input  logic              hi_rx_ready_i,
  output logic [FLIT_W-1:0] hi_rx_data_o,
  output logic              lo_rx_valid_o,
  input  logic              lo_rx_ready_i,
  output logic [FLIT_W-1:0] lo_rx_data_o
);
  localparam int NCH = 2;

  hdr_t             tx_hdr, out_hdr;
  logic [LEN_W-1:0] in_rem_q;
  logic             in_prio_q, in_hdr, cur_prio;

  assign tx_hdr   = hdr_t'(loc_tx_data_i);
  assign in_hdr   = (in_rem_q == '0);
  assign cur_prio = in_hdr ? tx_hdr.prio : in_prio_q;

  logic [NCH-1:0]    txf_iv, txf_ir, txf_ov, txf_or;
  logic [FLIT_W-1:0] txf_od [NCH];
  logic [NCH-1:0]    rxf_iv, rxf_ir, rxf_ov, rxf_or;
  logic [FLIT_W-1:0] rxf_od [NCH];

  logic             sel_lock_q, sel_ch_q, grant, ch, out_fire;
  logic [LEN_W:0]   sel_rem_q, total;

  assign grant = txf_ov[1];
  assign ch    = sel_lock_q ? sel_ch_q : grant;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign txf_iv[c] = loc_tx_valid_i && (cur_prio == 1'(c));
    assign txf_or[c] = net_tx_ready_i && (ch == 1'(c));
    assign rxf_iv[c] = net_rx_valid_i && (net_rx_prio_i == 1'(c));

    niu_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_txf (
      .clk_i, .rst_ni,
      .in_valid_i (txf_iv[c]), .in_ready_o (txf_ir[c]), .in_data_i (loc_tx_data_i),
      .out_valid_o(txf_ov[c]), .out_ready_i(txf_or[c]), .out_data_o(txf_od[c])
    );
    niu_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_rxf (
      .clk_i, .rst_ni,
      .in_valid_i (rxf_iv[c]), .in_ready_o (rxf_ir[c]), .in_data_i (net_rx_data_i),
      .out_valid_o(rxf_ov[c]), .out_ready_i(rxf_or[c]), .out_data_o(rxf_od[c])
    );
  end

  assign loc_tx_ready_o = txf_ir[cur_prio];
  assign net_rx_ready_o = rxf_ir[net_rx_prio_i];

  assign hi_rx_valid_o = rxf_ov[1];
  assign hi_rx_data_o  = rxf_od[1];
  assign rxf_or[1]     = hi_rx_ready_i;
  assign lo_rx_valid_o = rxf_ov[0];
  assign lo_rx_data_o  = rxf_od[0];
  assign rxf_or[0]     = lo_rx_ready_i;

  assign net_tx_valid_o = txf_ov[ch];
  assign net_tx_data_o  = txf_od[ch];
  assign out_hdr        = hdr_t'(net_tx_data_o);
  assign total          = {1'b0, out_hdr.len} + (LEN_W+1)'(1);
  assign out_fire       = net_tx_valid_o && net_tx_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rem_q  <= '0;
      in_prio_q <= 1'b0;
    end else if (loc_tx_valid_i && loc_tx_ready_o) begin
      if (in_hdr) begin
        in_rem_q  <= tx_hdr.len;
        in_prio_q <= tx_hdr.prio;
      end else begin
        in_rem_q  <= in_rem_q - 1'b1;
      end
    end
  end

  // channel locked from first presentation of a header to its last flit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_lock_q <= 1'b0;
      sel_ch_q   <= 1'b0;
      sel_rem_q  <= '0;
    end else if (!sel_lock_q) begin
      if (net_tx_valid_o) begin
        sel_ch_q <= grant;
        if (out_fire) begin
          sel_rem_q  <= total - 1'b1;
          sel_lock_q <= (out_hdr.len != '0);
        end else begin
          sel_rem_q  <= total;
          sel_lock_q <= 1'b1;
        end
      end
    end else if (out_fire) begin
      sel_rem_q <= sel_rem_q - 1'b1;
      if (sel_rem_q == (LEN_W+1)'(1)) sel_lock_q <= 1'b0;
    end
  end

  assert_chan_lock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_lock_q && !(out_fire && sel_rem_q == (LEN_W+1)'(1)))
      |=> (sel_lock_q && $stable(sel_ch_q)));
  assert_hi_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_lock_q && txf_ov[1]) |-> (net_tx_valid_o && out_hdr.prio));
endmodule

// File: rtl/niu_ring_xfer.sv
module niu_ring_xfer
  import niu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NODE_W-1:0] node_id_i,
  input  logic              ring_in_valid_i,
  output logic              ring_in_ready_o,
  input  logic [FLIT_W-1:0] ring_in_data_i,
  output logic              ring_out_valid_o,
  input  logic              ring_out_ready_i,
  output logic [FLIT_W-1:0] ring_out_data_o,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  input  logic [FLIT_W-1:0] tx_data_i,
  output logic              rx_valid_o,
  input  logic              rx_ready_i,
  output logic [FLIT_W-1:0] rx_data_o,
  output logic              rx_prio_o,
  output logic              loop_err_o
);
  hdr_t       in_hdr_f, out_hdr_f;
  logic [LEN_W-1:0] in_rem_q;
  in_mode_e   in_mode_q, hdr_mode, cur_mode;
  logic       in_prio_q, in_is_hdr, in_fire, fwd_req;
  out_own_e   out_own_q, grant, eff;
  logic [LEN_W:0] out_rem_q, total;
  logic       out_fire;

  assign in_hdr_f  = hdr_t'(ring_in_data_i);
  assign in_is_hdr = (in_rem_q == '0);

  always_comb begin
    if (in_hdr_f.dest == node_id_i)     hdr_mode = IN_EXT;
    else if (in_hdr_f.src == node_id_i) hdr_mode = IN_DROP;
    else                                hdr_mode = IN_FWD;
  end

  assign cur_mode = in_is_hdr ? hdr_mode : in_mode_q;
  assign fwd_req  = ring_in_valid_i && in_is_hdr && (hdr_mode == IN_FWD);

  always_comb begin
    if (fwd_req)         grant = OWN_FWD;
    else if (tx_valid_i) grant = OWN_INS;
    else                 grant = OWN_NONE;
  end
  assign eff = (out_own_q != OWN_NONE) ? out_own_q : grant;

  always_comb begin
    unique case (eff)
      OWN_FWD: begin ring_out_valid_o = ring_in_valid_i; ring_out_data_o = ring_in_data_i; end
      OWN_INS: begin ring_out_valid_o = tx_valid_i;      ring_out_data_o = tx_data_i;      end
      default: begin ring_out_valid_o = 1'b0;            ring_out_data_o = tx_data_i;      end
    endcase
  end

  always_comb begin
    unique case (cur_mode)
      IN_EXT:  ring_in_ready_o = rx_ready_i;
      IN_DROP: ring_in_ready_o = 1'b1;
      default: ring_in_ready_o = (eff == OWN_FWD) && ring_out_ready_i;
    endcase
  end

  assign tx_ready_o = (eff == OWN_INS) && ring_out_ready_i;
  assign rx_valid_o = ring_in_valid_i && (cur_mode == IN_EXT);
  assign rx_data_o  = ring_in_data_i;
  assign rx_prio_o  = in_is_hdr ? in_hdr_f.prio : in_prio_q;

  assign in_fire   = ring_in_valid_i && ring_in_ready_o;
  assign out_fire  = ring_out_valid_o && ring_out_ready_i;
  assign out_hdr_f = hdr_t'(ring_out_data_o);
  assign total     = {1'b0, out_hdr_f.len} + (LEN_W+1)'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_rem_q   <= '0;
      in_mode_q  <= IN_FWD;
      in_prio_q  <= 1'b0;
      loop_err_o <= 1'b0;
    end else begin
      loop_err_o <= in_fire && in_is_hdr && (hdr_mode == IN_DROP);
      if (in_fire) begin
        if (in_is_hdr) begin
          in_rem_q  <= in_hdr_f.len;
          in_mode_q <= hdr_mode;
          in_prio_q <= in_hdr_f.prio;
        end else begin
          in_rem_q  <= in_rem_q - 1'b1;
        end
      end
    end
  end

  // output owner latched when a header is first offered, held to its last flit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_own_q <= OWN_NONE;
      out_rem_q <= '0;
    end else if (out_own_q == OWN_NONE) begin
      if (ring_out_valid_o) begin
        if (out_fire) begin
          out_rem_q <= total - 1'b1;
          out_own_q <= (out_hdr_f.len != '0) ? grant : OWN_NONE;
        end else begin
          out_rem_q <= total;
          out_own_q <= grant;
        end
      end
    end else if (out_fire) begin
      out_rem_q <= out_rem_q - 1'b1;
      if (out_rem_q == (LEN_W+1)'(1)) out_own_q <= OWN_NONE;
    end
  end

  assert_out_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ring_out_valid_o && !ring_out_ready_i) |=> (ring_out_valid_o && $stable(ring_out_data_o)));
  assert_no_interleave_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_own_q != OWN_NONE && !(out_fire && out_rem_q == (LEN_W+1)'(1))) |=> $stable(out_own_q));
  assert_pass_first_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_own_q == OWN_NONE && ring_in_valid_i && in_is_hdr &&
     in_hdr_f.dest != node_id_i && in_hdr_f.src != node_id_i)
      |-> (ring_out_valid_o && ring_out_data_o == ring_in_data_i));
  assert_err_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_err_o |-> $past(ring_in_valid_i && ring_in_ready_o));
endmodule

// File: rtl/niu_ring_node.sv
module niu_ring_node
  import niu_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NODE_W-1:0] node_id_i,
  input  logic              loc_tx_valid_i,
  output logic              loc_tx_ready_o,
  input  logic [FLIT_W-1:0] loc_tx_data_i,
  output logic              hi_rx_valid_o,
  input  logic              hi_rx_ready_i,
  output logic [FLIT_W-1:0] hi_rx_data_o,
  output logic              lo_rx_valid_o,
  input  logic              lo_rx_ready_i,
  output logic [FLIT_W-1:0] lo_rx_data_o,
  input  logic              ring_in_valid_i,
  output logic              ring_in_ready_o,
  input  logic [FLIT_W-1:0] ring_in_data_i,
  output logic              ring_out_valid_o,
  input  logic              ring_out_ready_i,
  output logic [FLIT_W-1:0] ring_out_data_o,
  output logic              loop_err_o
);
  logic              tx_valid, tx_ready, rx_valid, rx_ready, rx_prio;
  logic [FLIT_W-1:0] tx_data, rx_data;

  niu_msg_queue #(.DEPTH(FIFO_DEPTH)) u_queue (
    .clk_i, .rst_ni,
    .loc_tx_valid_i, .loc_tx_ready_o, .loc_tx_data_i,
    .net_tx_valid_o(tx_valid), .net_tx_ready_i(tx_ready), .net_tx_data_o(tx_data),
    .net_rx_valid_i(rx_valid), .net_rx_ready_o(rx_ready), .net_rx_data_i(rx_data),
    .net_rx_prio_i (rx_prio),
    .hi_rx_valid_o, .hi_rx_ready_i, .hi_rx_data_o,
    .lo_rx_valid_o, .lo_rx_ready_i, .lo_rx_data_o
  );

  niu_ring_xfer u_xfer (
    .clk_i, .rst_ni, .node_id_i,
    .ring_in_valid_i, .ring_in_ready_o, .ring_in_data_i,
    .ring_out_valid_o, .ring_out_ready_i, .ring_out_data_o,
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .tx_data_i(tx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready), .rx_data_o(rx_data), .rx_prio_o(rx_prio),
    .loop_err_o
  );
endmodule

// File: tb/niu_ring_node_bench.sv
`timescale 1ns/1ps
module niu_ring_node_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  node_id_i = 4'd5;
  logic        loc_tx_valid_i = 1'b0;
  logic        loc_tx_ready_o;
  logic [31:0] loc_tx_data_i = '0;
  logic        hi_rx_valid_o, lo_rx_valid_o;
  logic        hi_rx_ready_i = 1'b1, lo_rx_ready_i = 1'b1;
  logic [31:0] hi_rx_data_o, lo_rx_data_o;
  logic        ring_in_valid_i = 1'b0;
  logic        ring_in_ready_o;
  logic [31:0] ring_in_data_i = '0;
  logic        ring_out_valid_o;
  logic        ring_out_ready_i = 1'b1;
  logic [31:0] ring_out_data_o;
  logic        loop_err_o;

  always #2 clk_i = ~clk_i;

  niu_ring_node u_niu_ring_node (.*);

  int n_chk = 0, n_bad = 0, err_cnt = 0;
  logic [31:0] out_log[$], hi_log[$], lo_log[$];

  always @(posedge clk_i) begin
    if (rst_ni) begin
      if (ring_out_valid_o && ring_out_ready_i) out_log.push_back(ring_out_data_o);
      if (hi_rx_valid_o && hi_rx_ready_i)       hi_log.push_back(hi_rx_data_o);
      if (lo_rx_valid_o && lo_rx_ready_i)       lo_log.push_back(lo_rx_data_o);
      if (loop_err_o) err_cnt++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_log(input string req, input logic [31:0] got[$], input logic [31:0] exp[$]);
    chk(got.size() == exp.size(), req, got.size(), exp.size());
    for (int i = 0; i < exp.size() && i < got.size(); i++)
      chk(got[i] == exp[i], req, got[i], exp[i]);
  endtask

  // R2 header layout
  function automatic logic [31:0] mk_hdr(input logic p, input logic [3:0] d, input logic [3:0] s,
                                         input logic [3:0] l, input logic [7:0] t, input logic [7:0] c);
    return {p, d, s, l, t, c, 3'b000};
  endfunction

  task automatic clear_logs();
    out_log.delete(); hi_log.delete(); lo_log.delete(); err_cnt = 0;
  endtask

  task automatic ring_flit(input logic [31:0] f);
    logic got;
    ring_in_data_i = f; ring_in_valid_i = 1'b1;
    do begin
      #1 got = ring_in_ready_o;
      @(negedge clk_i);
    end while (!got);
    ring_in_valid_i = 1'b0;
  endtask

  task automatic loc_flit(input logic [31:0] f);
    logic got;
    loc_tx_data_i = f; loc_tx_valid_i = 1'b1;
    do begin
      #1 got = loc_tx_ready_o;
      @(negedge clk_i);
    end while (!got);
    loc_tx_valid_i = 1'b0;
  endtask

  // {prio, dest, src, kind}; kind 0 forward, 1 hi rx, 2 lo rx, 3 drop; node id 5
  localparam logic [10:0] VEC [8] = '{
    11'b1_0101_0010_01, 11'b0_0101_0011_10, 11'b1_0111_0010_00, 11'b0_0011_0101_11,
    11'b1_0101_0101_01, 11'b0_1001_0001_00, 11'b0_0101_0101_10, 11'b1_0010_0101_11
  };

  initial begin
    repeat (3) @(negedge clk_i);
    chk(ring_out_valid_o == 1'b0, "R1 ring_out_valid", ring_out_valid_o, 0);
    chk(hi_rx_valid_o == 1'b0, "R1 hi_rx_valid", hi_rx_valid_o, 0);
    chk(lo_rx_valid_o == 1'b0, "R1 lo_rx_valid", lo_rx_valid_o, 0);
    chk(loop_err_o == 1'b0, "R1 loop_err", loop_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ring_out_valid_o == 1'b0, "R1 ring_out idle after reset", ring_out_valid_o, 0);

    // table walk: R5 R6 R8
    for (int v = 0; v < 8; v++) begin
      logic [31:0] h, p;
      logic [31:0] none[$], pair[$];
      logic [1:0] kind;
      kind = VEC[v][1:0];
      h = mk_hdr(VEC[v][10], VEC[v][9:6], VEC[v][5:2], 4'd1, 8'(v), 8'h3C);
      p = 32'hA000_0000 + v;
      pair = '{h, p};
      clear_logs();
      ring_flit(h);
      ring_flit(p);
      repeat (8) @(negedge clk_i);
      case (kind)
        2'd0: begin chk_log("R6 forwarded", out_log, pair); chk_log("R6 not extracted", hi_log, none); end
        2'd1: begin chk_log("R5 hi rx", hi_log, pair); chk_log("R5 not forwarded", out_log, none); end
        2'd2: begin chk_log("R5 lo rx", lo_log, pair); chk_log("R5 not forwarded", out_log, none); end
        default: begin
          chk_log("R8 dropped out", out_log, none);
          chk_log("R8 dropped rx", hi_log, none);
          chk_log("R8 dropped lo", lo_log, none);
          chk(err_cnt == 1, "R8 one error pulse", err_cnt, 1);
        end
      endcase
      if (kind != 2'd3) chk(err_cnt == 0, "R8 no error pulse", err_cnt, 0);
    end

    // R4 R9 R3: stalled output, then lo A(len1), lo B(len0), hi C(len0)
    begin
      logic [31:0] ah, ap, bh, ch, d0, d1;
      logic [31:0] exp[$];
      ah = mk_hdr(1'b0, 4'd9, 4'd5, 4'd1, 8'h11, 8'h01);
      ap = 32'hB000_0001;
      bh = mk_hdr(1'b0, 4'd9, 4'd5, 4'd0, 8'h22, 8'h02);
      ch = mk_hdr(1'b1, 4'd9, 4'd5, 4'd0, 8'h33, 8'h03);
      clear_logs();
      ring_out_ready_i = 1'b0;
      loc_flit(ah); loc_flit(ap); loc_flit(bh); loc_flit(ch);
      d0 = ring_out_data_o;
      chk(ring_out_valid_o == 1'b1, "R9 valid held under stall", ring_out_valid_o, 1);
      repeat (3) @(negedge clk_i);
      d1 = ring_out_data_o;
      chk(d0 == ah && d1 == ah, "R9 data held under stall", d1, ah);
      ring_out_ready_i = 1'b1;
      repeat (10) @(negedge clk_i);
      exp = '{ah, ap, ch, bh};
      chk_log("R4 hi before lo at boundary", out_log, exp);
    end

    // R7 R3: passing messages win over waiting local insert
    begin
      logic [31:0] m1h, m1p, m2h, m2p, lh, lp;
      logic [31:0] exp[$];
      m1h = mk_hdr(1'b0, 4'd8, 4'd2, 4'd1, 8'h41, 8'h00); m1p = 32'hC000_0001;
      m2h = mk_hdr(1'b1, 4'd8, 4'd3, 4'd1, 8'h42, 8'h00); m2p = 32'hC000_0002;
      lh  = mk_hdr(1'b1, 4'd9, 4'd5, 4'd1, 8'h43, 8'h00); lp  = 32'hC000_0003;
      clear_logs();
      ring_out_ready_i = 1'b0;
      fork
        begin ring_flit(m1h); ring_flit(m1p); ring_flit(m2h); ring_flit(m2p); end
        begin loc_flit(lh); loc_flit(lp); end
        begin repeat (6) @(negedge clk_i); ring_out_ready_i = 1'b1; end
      join
      repeat (10) @(negedge clk_i);
      exp = '{m1h, m1p, m2h, m2p, lh, lp};
      chk_log("R7 passing first, R3 whole messages", out_log, exp);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule